// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Array

This block is a square grid of one-bit processing elements wired as a two-dimensional torus. A single micro-instruction is broadcast to every element in a cycle. Each element holds three one-bit registers: an accumulator Q, a carry C and an activity flag A. It also holds a small private memory of single bits, addressed by the broadcast address.

Every element has a full adder. Two of its inputs are Q and C. The third input is chosen by a source selector. The selector can pick the element's own memory bit, its Q, its A, the C of one of its four torus neighbours, a broadcast bit, or that element's bit of an input plane. Results can be written back to the element's memory only in elements whose A is set. Register loads go ahead in every element regardless of A.

The controller feeds instructions through a valid/ready pair. The array accepts one instruction in every cycle, so ready is always high and there is never back-pressure. A cycle without valid is an idle cycle. For inspection, the array drives the Q, C and A planes and the memory plane at the current address.

Top module: `bsa_array`

## Requirements
- R1: After reset, every element has Q=0, C=0, A=1 and all memory bits at 0.
- R2: Source select codes: 0 memory bit at the address, 1 Q, 2 A, 3 neighbour C, 4 broadcast bit, 5 the element's plane input bit. Codes 6 and 7 give 0. A load of A takes the selected source value.
- R3: A Q load sets Q to Q xor C xor source. A C load sets C to the majority of Q, C and source. Both loads use the values held before the instruction.
- R4: When instr_valid is low, Q, C, A and memory do not change. When valid is high, a register whose load bit is clear keeps its value.
- R5: A memory write stores the sum (wr_sum=1) or the source value (wr_sum=0) at the address. It takes effect only when the element's A, as held before the instruction, is 1.
- R6: In elements with A=0, the memory write is suppressed, but register loads in the same instruction still take effect.
- R7: Neighbour direction codes: 0 north (row-1), 1 east (col+1), 2 south (row+1), 3 west (col-1). Indices wrap at the edges. Element (row,col) is bit row*DIM+col of every plane.
- R8: Steps over consecutive addresses with a C load and a sum write, but no Q load, add a memory word to the word that repeats Q in every bit, plus the initial C, least significant bit first. With Q=0 and C=1 this increments the word; with Q=1 and C=0 it decrements it.
- R9: mem_plane shows, for every element, its memory bit at mem_addr without delay.
- R10: instr_ready is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr_ready | output | 1 | Always high |
| src_sel | input | 3 | Adder third-input source |
| nbr_dir | input | 2 | Neighbour direction |
| mem_addr | input | $clog2(MEM_BITS) | Broadcast memory address |
| ld_q | input | 1 | Load Q with sum |
| ld_c | input | 1 | Load C with carry-out |
| ld_a | input | 1 | Load A with source |
| mem_we | input | 1 | Memory write request (gated by A) |
| wr_sum | input | 1 | Write sum (1) or source (0) |
| bcast_bit | input | 1 | Broadcast data bit |
| plane_in | input | DIM*DIM | Per-element input bits |
| q_plane | output | DIM*DIM | Q of all elements |
| c_plane | output | DIM*DIM | C of all elements |
| a_plane | output | DIM*DIM | A of all elements |
| mem_plane | output | DIM*DIM | Memory bit at mem_addr, all elements |

## Verification
The hardest cases to reach from the ports are those that need elements to differ from one another. Torus wrap-around and write gating only show up when neighbouring elements hold different C or A values. The stimulus first sets Q to 1 in every element. It then loads C from distinct plane-input patterns, since a carry load with Q=1 and C=0 copies the source into C. Next it loads A from each neighbour direction in turn, so the A plane exposes the routing. It then writes under a mixed A plane and reads back through mem_plane. Serial arithmetic is checked by loading per-element words through the plane input and comparing the incremented and decremented words against plain integer arithmetic.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  localparam logic [2:0] SRC_MEM   = 3'd0;
  localparam logic [2:0] SRC_Q     = 3'd1;
  localparam logic [2:0] SRC_A     = 3'd2;
  localparam logic [2:0] SRC_NBR   = 3'd3;
  localparam logic [2:0] SRC_BCAST = 3'd4;
  localparam logic [2:0] SRC_PLANE = 3'd5;

  localparam logic [1:0] DIR_N = 2'd0;
  localparam logic [1:0] DIR_E = 2'd1;
  localparam logic [1:0] DIR_S = 2'd2;
  localparam logic [1:0] DIR_W = 2'd3;

  typedef struct packed {
    logic [2:0] src;
    logic [1:0] dir;
    logic       ld_q;
    logic       ld_c;
    logic       ld_a;
    logic       mem_we;
    logic       wr_sum;
  } uop_t;
endpackage

// File: rtl/bsa_nbr_route.sv
module bsa_nbr_route #(
  parameter int DIM = 4,
  localparam int NE = DIM * DIM
) (
  input  logic [NE-1:0]      c_plane,
  output logic [NE-1:0][3:0] nbr_c
);
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar col = 0; col < DIM; col++) begin : g_col
      localparam int E  = r * DIM + col;
      localparam int RN = (r + DIM - 1) % DIM;
      localparam int RS = (r + 1) % DIM;
      localparam int CE = (col + 1) % DIM;
      localparam int CW = (col + DIM - 1) % DIM;
      assign nbr_c[E][0] = c_plane[RN * DIM + col];
      assign nbr_c[E][1] = c_plane[r * DIM + CE];
      assign nbr_c[E][2] = c_plane[RS * DIM + col];
      assign nbr_c[E][3] = c_plane[r * DIM + CW];
    end
  end
endmodule

// File: rtl/bsa_pe.sv
module bsa_pe
  import bsa_pkg::*;
#(
  parameter int MEM_BITS = 16,
  localparam int AW = $clog2(MEM_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  uop_t          uop,
  input  logic [AW-1:0] addr,
  input  logic          bcast,
  input  logic          plane_bit,
  input  logic [3:0]    nbr_c,
  output logic          q,
  output logic          c,
  output logic          a,
  output logic          mem_bit
);
  logic [MEM_BITS-1:0] mem_r;
  logic q_r, c_r, a_r;
  logic mux, sum, cout;

  always_comb begin
    case (uop.src)
      SRC_MEM:   mux = mem_r[addr];
      SRC_Q:     mux = q_r;
      SRC_A:     mux = a_r;
      SRC_NBR:   mux = nbr_c[uop.dir];
      SRC_BCAST: mux = bcast;
      SRC_PLANE: mux = plane_bit;
      default:   mux = 1'b0;
    endcase
  end

  assign sum  = q_r ^ c_r ^ mux;
  assign cout = (q_r & c_r) | (q_r & mux) | (c_r & mux);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r   <= 1'b0;
      c_r   <= 1'b0;
      a_r   <= 1'b1;
      mem_r <= '0;
    end else if (op_valid) begin
      if (uop.ld_q) q_r <= sum;
      if (uop.ld_c) c_r <= cout;
      if (uop.ld_a) a_r <= mux;
      if (uop.mem_we && a_r) mem_r[addr] <= uop.wr_sum ? sum : mux;
    end
  end

  assign q       = q_r;
  assign c       = c_r;
  assign a       = a_r;
  assign mem_bit = mem_r[addr];

  // R6
  gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && uop.mem_we && !a_r) |=> mem_r[$past(addr)] == $past(mem_r[addr]));
  // R4
  hold_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || !uop.ld_q) |=> $stable(q_r));
  // R4
  hold_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || !uop.ld_c) |=> $stable(c_r));
  // R4
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || !uop.ld_a) |=> $stable(a_r));
  // R4
  idle_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid) |=> $stable(mem_r));
endmodule

// File: rtl/bsa_array.sv
module bsa_array
  import bsa_pkg::*;
#(
  parameter int DIM = 4,
  parameter int MEM_BITS = 16,
  localparam int NE = DIM * DIM,
  localparam int AW = $clog2(MEM_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [2:0]    src_sel,
  input  logic [1:0]    nbr_dir,
  input  logic [AW-1:0] mem_addr,
  input  logic          ld_q,
  input  logic          ld_c,
  input  logic          ld_a,
  input  logic          mem_we,
  input  logic          wr_sum,
  input  logic          bcast_bit,
  input  logic [NE-1:0] plane_in,
  output logic [NE-1:0] q_plane,
  output logic [NE-1:0] c_plane,
  output logic [NE-1:0] a_plane,
  output logic [NE-1:0] mem_plane
);
  uop_t uop;
  logic [NE-1:0][3:0] nbr_c;

  assign instr_ready = 1'b1;
  assign uop = '{src: src_sel, dir: nbr_dir, ld_q: ld_q, ld_c: ld_c,
                 ld_a: ld_a, mem_we: mem_we, wr_sum: wr_sum};

  bsa_nbr_route #(.DIM(DIM)) u_route (
    .c_plane (c_plane),
    .nbr_c   (nbr_c)
  );

  for (genvar e = 0; e < NE; e++) begin : g_pe
    bsa_pe #(.MEM_BITS(MEM_BITS)) u_pe (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (instr_valid),
      .uop       (uop),
      .addr      (mem_addr),
      .bcast     (bcast_bit),
      .plane_bit (plane_in[e]),
      .nbr_c     (nbr_c[e]),
      .q         (q_plane[e]),
      .c         (c_plane[e]),
      .a         (a_plane[e]),
      .mem_bit   (mem_plane[e])
    );
  end

  // R2
  bcast_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && ld_a && src_sel == SRC_BCAST) |=> a_plane == {NE{$past(bcast_bit)}});
  // R3
  q_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && ld_q && src_sel == SRC_Q && c_plane == '0) |=> q_plane == '0);
endmodule

// File: tb/bsa_array_bench.sv
module bsa_array_bench;
  localparam int DIM = 4;
  localparam int NE = 16;
  localparam int MB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic instr_ready;
  logic [2:0] src_sel = '0;
  logic [1:0] nbr_dir = '0;
  logic [3:0] mem_addr = '0;
  logic ld_q = 0, ld_c = 0, ld_a = 0, mem_we = 0, wr_sum = 0, bcast_bit = 0;
  logic [NE-1:0] plane_in = '0;
  logic [NE-1:0] q_plane, c_plane, a_plane, mem_plane;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NE-1:0] mq, mc, ma;
  logic [MB-1:0] mm [NE];

  always #10 clk = ~clk;

  bsa_array #(.DIM(DIM), .MEM_BITS(MB)) u_bsa_array (
    .clk, .rst_n, .instr_valid, .instr_ready, .src_sel, .nbr_dir, .mem_addr,
    .ld_q, .ld_c, .ld_a, .mem_we, .wr_sum, .bcast_bit, .plane_in,
    .q_plane, .c_plane, .a_plane, .mem_plane
  );

  // src[30:28] dir[27:26] addr[25:22] ldq ldc lda we ws bc [21:16] plane[15:0]
  localparam logic [30:0] VEC [14] = '{
    {3'd4, 2'd0, 4'd0, 6'b100001, 16'h0000},  // Q=1          R3
    {3'd5, 2'd0, 4'd0, 6'b010000, 16'hA5C3},  // C=plane      R3
    {3'd5, 2'd0, 4'd2, 6'b000100, 16'h1234},  // mem[2]=plane R5
    {3'd3, 2'd0, 4'd0, 6'b001000, 16'h0000},  // A=north C    R7
    {3'd3, 2'd1, 4'd0, 6'b001000, 16'h0000},  // A=east C     R7
    {3'd3, 2'd2, 4'd0, 6'b001000, 16'h0000},  // A=south C    R7
    {3'd3, 2'd3, 4'd0, 6'b001000, 16'h0000},  // A=west C     R7
    {3'd5, 2'd0, 4'd0, 6'b001000, 16'h0F0F},  // A=plane      R2
    {3'd0, 2'd0, 4'd2, 6'b000110, 16'h0000},  // gated sum wr R5 R6
    {3'd0, 2'd0, 4'd2, 6'b110000, 16'h0000},  // Q,C from mem R3
    {3'd1, 2'd0, 4'd0, 6'b001000, 16'h0000},  // A=Q          R2
    {3'd2, 2'd0, 4'd0, 6'b101000, 16'h0000},  // A=A, Q load  R2
    {3'd6, 2'd0, 4'd0, 6'b001000, 16'h0000},  // code 6 -> 0  R2
    {3'd4, 2'd0, 4'd0, 6'b001001, 16'h0000}   // A=bcast 1    R2
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    mq = '0; mc = '0; ma = '1;
    for (int e = 0; e < NE; e++) mm[e] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; instr_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic op(input logic v, input logic [2:0] s, input logic [1:0] d,
                    input logic [3:0] ad, input logic [5:0] ctl,
                    input logic [15:0] pl, input string tag);
    logic [NE-1:0] nq, nc, na;
    @(negedge clk);
    instr_valid = v; src_sel = s; nbr_dir = d; mem_addr = ad;
    {ld_q, ld_c, ld_a, mem_we, wr_sum, bcast_bit} = ctl;
    plane_in = pl;
    nq = mq; nc = mc; na = ma;
    if (v) begin
      for (int e = 0; e < NE; e++) begin
        int r, cl, nb;
        logic mx, sm, co;
        r = e / DIM; cl = e % DIM;
        case (d)
          2'd0: nb = ((r + DIM - 1) % DIM) * DIM + cl;
          2'd1: nb = r * DIM + (cl + 1) % DIM;
          2'd2: nb = ((r + 1) % DIM) * DIM + cl;
          default: nb = r * DIM + (cl + DIM - 1) % DIM;
        endcase
        case (s)
          3'd0: mx = mm[e][ad];
          3'd1: mx = mq[e];
          3'd2: mx = ma[e];
          3'd3: mx = mc[nb];
          3'd4: mx = ctl[0];
          3'd5: mx = pl[e];
          default: mx = 1'b0;
        endcase
        sm = mq[e] ^ mc[e] ^ mx;
        co = (mq[e] + mc[e] + mx) >= 2;
        if (ctl[5]) nq[e] = sm;
        if (ctl[4]) nc[e] = co;
        if (ctl[3]) na[e] = mx;
        if (ctl[2] && ma[e]) mm[e][ad] = ctl[1] ? sm : mx;
      end
    end
    mq = nq; mc = nc; ma = na;
    @(negedge clk);
    instr_valid = 1'b0;
    #2;
    chk({tag, " planes"}, {16'h0, q_plane, c_plane, a_plane}, {16'h0, mq, mc, ma});
    begin
      logic [NE-1:0] em;
      for (int e = 0; e < NE; e++) em[e] = mm[e][ad];
      chk({tag, " mem_plane R9"}, {48'h0, mem_plane}, {48'h0, em});
    end
  endtask

  function automatic logic [15:0] bit_plane(input int k, input int ofs);
    logic [15:0] p;
    for (int e = 0; e < NE; e++) p[e] = 1'((((e + ofs) % 16) >> k) & 1);
    return p;
  endfunction

  task automatic read_word(output logic [3:0] w [NE]);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      mem_addr = 4'(k);
      #2;
      for (int e = 0; e < NE; e++) w[e][k] = mem_plane[e];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] w [NE];
    model_reset();
    do_reset();
    #2;
    // R1 reset state, R10 ready
    chk("R1 reset planes", {16'h0, q_plane, c_plane, a_plane}, {16'h0, 16'h0, 16'h0, 16'hFFFF});
    chk("R1 reset mem_plane", {48'h0, mem_plane}, 64'h0);
    chk("R10 instr_ready", {63'h0, instr_ready}, 64'h1);

    for (int i = 0; i < 14; i++)
      op(1'b1, VEC[i][30:28], VEC[i][27:26], VEC[i][25:22], VEC[i][21:16], VEC[i][15:0],
         $sformatf("vector %0d R2 R3 R5 R6 R7", i));

    // R4 idle cycle with load bits set
    op(1'b0, 3'd4, 2'd0, 4'd2, 6'b111111, 16'hFFFF, "R4 idle");
    // R4 valid with no load bits
    op(1'b1, 3'd5, 2'd0, 4'd2, 6'b000000, 16'hFFFF, "R4 no loads");

    // R6 write gated by a mixed A plane, Q load still happens
    do_reset();
    op(1'b1, 3'd5, 2'd0, 4'd0, 6'b001000, 16'h3C69, "R6 set A");
    op(1'b1, 3'd4, 2'd0, 4'd5, 6'b100101, 16'h0000, "R6 gated write");
    chk("R6 mem follows A", {48'h0, mem_plane}, {48'h0, 16'h3C69});
    chk("R6 Q loaded in all", {48'h0, q_plane}, {48'h0, 16'hFFFF});

    // R8 increment: Q=0, C=1
    do_reset();
    for (int k = 0; k < 4; k++)
      op(1'b1, 3'd5, 2'd0, 4'(k), 6'b000100, bit_plane(k, 0), "R8 load word");
    op(1'b1, 3'd4, 2'd0, 4'd0, 6'b100001, 16'h0, "R8 Q=1");
    op(1'b1, 3'd4, 2'd0, 4'd0, 6'b010001, 16'h0, "R8 C=1");
    op(1'b1, 3'd4, 2'd0, 4'd0, 6'b100000, 16'h0, "R8 Q=0");
    for (int k = 0; k < 4; k++)
      op(1'b1, 3'd0, 2'd0, 4'(k), 6'b010110, 16'h0, "R8 inc step");
    read_word(w);
    for (int e = 0; e < NE; e++)
      chk($sformatf("R8 increment elem %0d", e), {60'h0, w[e]}, 64'((e + 1) % 16));

    // R8 decrement: Q=1, C=0
    do_reset();
    for (int k = 0; k < 4; k++)
      op(1'b1, 3'd5, 2'd0, 4'(k), 6'b000100, bit_plane(k, 3), "R8 load word");
    op(1'b1, 3'd4, 2'd0, 4'd0, 6'b100001, 16'h0, "R8 Q=1");
    for (int k = 0; k < 4; k++)
      op(1'b1, 3'd0, 2'd0, 4'(k), 6'b010110, 16'h0, "R8 dec step");
    read_word(w);
    for (int e = 0; e < NE; e++)
      chk($sformatf("R8 decrement elem %0d", e), {60'h0, w[e]}, 64'((e + 3 + 15) % 16));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule